// File: doc/BRIEF.md
# Shared-Counter Multichannel PWM Generator

This block drives up to four pulse-width-modulated channels from one prescaled up-counter. All channels share a single prescaler and a single reload value, so they all have the same period. Each channel sets its own pulse width with a compare value. Each channel has a main output and a complementary output, each with its own polarity. Software reaches every setting through a simple single-cycle register-write port. Reload and compare values can be double-buffered, so that a new setting never splits a period.

An update event copies the buffered values into the working registers. It happens when the counter wraps from the reload value to zero, or at once when software writes the update strobe. A global output-enable bit gates every output. A kill input comes from a separate fault-handling block. It forces every output to its idle level and clears that enable bit.

Top module: `pwm_shared_gen`

## Requirements
- R1: The prescaler value is written at address 0 and the reload value at address 1. The shared period is (prescaler + 1) × (reload + 1) clock cycles, and all channels use it.
- R2: The compare value of channel n is written at address 2+n. Channel n is configured by four bits of the channel control word at address 6: bit 4n enables the channel, bit 4n+1 sets main polarity, bit 4n+2 enables the complementary output, and bit 4n+3 sets complementary polarity. With the polarity bit at 0, an enabled channel's main output is high while the counter is below its compare value. This gives compare × (prescaler + 1) high cycles per period.
- R3: A compare value of 0 gives a constant inactive main output. A compare value above the reload value gives a constant active main output.
- R4: The global control word is at address 7. When its bit 1 (reload buffering) is set, a reload write takes effect only at the next update event. When bit 1 is clear, a reload write takes effect immediately.
- R5: Bit 3+n of the global control word enables compare buffering for channel n. When that bit is set, a compare write takes effect only at the next update event. When it is clear, a compare write takes effect immediately.
- R6: Any write to address 8 is an update strobe. It loads all buffered values at once, including the prescaler, and restarts the counter and the prescaler from zero. Outside of update events, a written prescaler value is not used.
- R7: Setting the polarity bit inverts the main output. A disabled channel holds its main output at the level of its polarity bit.
- R8: An enabled complementary output is the inverse of the channel's raw compare result, then XORed with the complementary polarity bit. A disabled complementary output holds the level of its polarity bit.
- R9: Bit 2 of the global control word enables the outputs. When it is clear, both outputs of every channel sit at their polarity levels. While kill is high, the outputs sit at those same levels and bit 2 is cleared. The outputs stay idle after kill falls, until software sets bit 2 again.
- R10: Bit 0 of the global control word enables the counter. When it is clear, the counter holds its value and every output stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | DATA_W | Write data |
| kill_i | input | 1 | Fault kill from the fault-handling block |
| pwm_o | output | NUM_CH | Main output of each channel |
| pwmn_o | output | NUM_CH | Complementary output of each channel |

## Verification
The assertions take for granted that each write is a one-cycle pulse on the write port. They also assume that the kill input is synchronous to the clock. Under those conditions the idle levels, the complementary relation and the frozen counter can be checked against the register values of the previous cycle alone.

The stimulus makes every write through the write task. It raises kill only between clock edges. It makes mid-period reload and compare writes only early in a period, while the counter is still below both the old and the new values. It only raises the reload while buffering is off, so the counter never passes a reload value that was lowered.

// File: rtl/pwm_shared_pkg.sv
package pwm_shared_pkg;
  localparam int ADDR_W = 4;

  // Register addresses
  localparam logic [ADDR_W-1:0] A_PSC   = 4'd0;
  localparam logic [ADDR_W-1:0] A_ARR   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMP0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CHCTL = 4'd6;
  localparam logic [ADDR_W-1:0] A_GLOB  = 4'd7;
  localparam logic [ADDR_W-1:0] A_UG    = 4'd8;

  // Global control bit positions
  localparam int GB_CEN   = 0;
  localparam int GB_ARPE  = 1;
  localparam int GB_MOE   = 2;
  localparam int GB_OCPE0 = 3;

  // Per-channel field stride in the channel control word
  localparam int CH_STRIDE = 4;

  typedef struct packed {
    logic npol;
    logic nen;
    logic pol;
    logic en;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen,
  input  logic             arpe,
  input  logic             ug,
  input  logic             psc_wr,
  input  logic             arr_wr,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic [CNT_W-1:0] arr_wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ue_o
);
  logic [PSC_W-1:0] div_q, div_d, psc_pre_q, psc_pre_d, psc_act_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, arr_pre_q, arr_pre_d, arr_act_q;
  logic tick, wrap, ue, div_en, cnt_en, arr_act_en;

  always_comb begin
    tick       = cen && (div_q == psc_act_q);
    wrap       = tick && (cnt_q == arr_act_q);
    ue         = wrap || ug;
    div_en     = cen || ug;
    cnt_en     = tick || ug;
    div_d      = (ug || tick) ? '0 : div_q + 1'b1;
    cnt_d      = ue ? '0 : cnt_q + 1'b1;
    psc_pre_d  = psc_wr ? psc_wdata : psc_pre_q;
    arr_pre_d  = arr_wr ? arr_wdata : arr_pre_q;
    arr_act_en = (arr_wr && !arpe) || ue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_pre_q <= '0;
      arr_pre_q <= '1;
    end else begin
      psc_pre_q <= psc_pre_d;
      arr_pre_q <= arr_pre_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  psc_act_q <= '0;
    else if (ue) psc_act_q <= psc_pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          arr_act_q <= '1;
    else if (arr_act_en) arr_act_q <= arr_pre_d;
  end

  assign cnt_o = cnt_q;
  assign ue_o  = ue;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_shared_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ue,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             ocpe,
  input  chan_cfg_t        cfg,
  input  logic             out_on,
  output logic             pwm_o,
  output logic             pwmn_o
);
  logic [CNT_W-1:0] ccr_pre_q, ccr_pre_d, ccr_act_q;
  logic ccr_act_en, ref_lvl, main_d, comp_d, main_q, comp_q;

  always_comb begin
    ccr_pre_d  = cmp_wr ? cmp_wdata : ccr_pre_q;
    ccr_act_en = (cmp_wr && !ocpe) || ue;
    ref_lvl    = (cnt < ccr_act_q);
    main_d     = (cfg.en  && out_on) ? (ref_lvl ^ cfg.pol)   : cfg.pol;
    comp_d     = (cfg.nen && out_on) ? (!ref_lvl ^ cfg.npol) : cfg.npol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ccr_pre_q <= '0;
    else        ccr_pre_q <= ccr_pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ccr_act_q <= '0;
    else if (ccr_act_en) ccr_act_q <= ccr_pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= 1'b0;
      comp_q <= 1'b0;
    end else begin
      main_q <= main_d;
      comp_q <= comp_d;
    end
  end

  assign pwm_o  = main_q;
  assign pwmn_o = comp_q;
endmodule

// File: rtl/pwm_shared_gen.sv
module pwm_shared_gen
  import pwm_shared_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              kill_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] pwmn_o
);
  localparam int CTL_W  = NUM_CH * CH_STRIDE;
  localparam int GLOB_W = GB_OCPE0 + NUM_CH;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [CTL_W-1:0]  chctl_q, chctl_d;
  logic [GLOB_W-1:0] glob_q, glob_d;
  logic              chctl_wr, glob_wr, psc_wr, arr_wr, ug;
  logic              moe, cen, arpe, out_on, ue;
  logic [CNT_W-1:0]  cnt;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    psc_wr   = wr_en && (wr_addr == A_PSC);
    arr_wr   = wr_en && (wr_addr == A_ARR);
    chctl_wr = wr_en && (wr_addr == A_CHCTL);
    glob_wr  = wr_en && (wr_addr == A_GLOB);
    ug       = wr_en && (wr_addr == A_UG);
    chctl_d  = chctl_wr ? wr_data[CTL_W-1:0] : chctl_q;
    glob_d   = glob_wr ? wr_data[GLOB_W-1:0] : glob_q;
    if (kill_i) glob_d[GB_MOE] = 1'b0;
    moe      = glob_q[GB_MOE];
    cen      = glob_q[GB_CEN];
    arpe     = glob_q[GB_ARPE];
    out_on   = moe && !kill_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      chctl_q <= '0;
      glob_q  <= '0;
    end else begin
      chctl_q <= chctl_d;
      glob_q  <= glob_d;
    end
  end

  pwm_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_timebase (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cen       (cen),
    .arpe      (arpe),
    .ug        (ug),
    .psc_wr    (psc_wr),
    .arr_wr    (arr_wr),
    .psc_wdata (wr_data[PSC_W-1:0]),
    .arr_wdata (wr_data[CNT_W-1:0]),
    .cnt_o     (cnt),
    .ue_o      (ue)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] CMP_ADDR = A_CMP0 + ADDR_W'(g);
    pwm_channel #(.CNT_W(CNT_W)) u_channel (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .cnt       (cnt),
      .ue        (ue),
      .cmp_wr    (wr_en && (wr_addr == CMP_ADDR)),
      .cmp_wdata (wr_data[CNT_W-1:0]),
      .ocpe      (glob_q[GB_OCPE0+g]),
      .cfg       (chan_cfg_t'(chctl_q[g*CH_STRIDE +: CH_STRIDE])),
      .out_on    (out_on),
      .pwm_o     (pwm_o[g]),
      .pwmn_o    (pwmn_o[g])
    );
  end
endmodule

// File: rtl/pwm_shared_gen_chk.sv
module pwm_shared_gen_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  kill_i,
  input logic                  moe,
  input logic                  cen,
  input logic                  ug,
  input logic                  ue,
  input logic [CNT_W-1:0]      cnt,
  input logic [NUM_CH*4-1:0]   chctl,
  input logic [NUM_CH-1:0]     pwm_o,
  input logic [NUM_CH-1:0]     pwmn_o
);
  logic [NUM_CH-1:0] en_v, pol_v, nen_v, npol_v;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      en_v[i]   = chctl[4*i];
      pol_v[i]  = chctl[4*i+1];
      nen_v[i]  = chctl[4*i+2];
      npol_v[i] = chctl[4*i+3];
    end
  end

  // R9
  kill_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> ((pwm_o == $past(pol_v)) && (pwmn_o == $past(npol_v))));

  // R9
  moe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(moe) |-> ((pwm_o == $past(pol_v)) && (pwmn_o == $past(npol_v))));

  // R7
  off_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pwm_o ^ $past(pol_v)) & ~$past(en_v)) == '0));

  // R8
  comp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((((pwm_o ^ pwmn_o) ^ ~($past(pol_v) ^ $past(npol_v)))
      & $past(en_v & nen_v & {NUM_CH{moe && !kill_i}})) == '0));

  // R10
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cen) && !$past(ug)) |-> $stable(cnt));

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ue) |-> (cnt == '0));
endmodule

bind pwm_shared_gen pwm_shared_gen_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_int_n),
  .kill_i (kill_i),
  .moe    (moe),
  .cen    (cen),
  .ug     (ug),
  .ue     (ue),
  .cnt    (cnt),
  .chctl  (chctl_q),
  .pwm_o  (pwm_o),
  .pwmn_o (pwmn_o)
);

// File: tb/pwm_shared_gen_bench.sv
`timescale 1ns/1ps
module pwm_shared_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        kill_i;
  logic [3:0]  pwm_o, pwmn_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_shared_gen u_pwm_shared_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .kill_i(kill_i), .pwm_o(pwm_o), .pwmn_o(pwmn_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; kill_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic start(input logic [15:0] psc, input logic [15:0] arr, input logic [15:0] glob);
    wr(4'd0, psc);
    wr(4'd1, arr);
    wr(4'd7, glob);
    wr(4'd8, 16'd0);
    repeat (4) @(negedge clk);
  endtask

  task automatic count_high(input int ch, input bit comp, input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (comp ? pwmn_o[ch] : pwm_o[ch]) k++;
    end
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    prev = pwm_o[ch];
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!prev && pwm_o[ch]) return;
      prev = pwm_o[ch];
    end
    chk(1'b0, "rise timeout", 0, 1);
  endtask

  // Called right after a rising edge; counts cycles to the next one,
  // optionally writing a register early in the period.
  task automatic next_rise(input int ch, input bit do_wr, input logic [3:0] a,
                           input logic [15:0] d, output int n);
    logic prev;
    prev = 1'b1;
    n = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      n++;
      if (do_wr && n == 1) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
      if (n == 2) wr_en = 1'b0;
      if (!prev && pwm_o[ch]) return;
      prev = pwm_o[ch];
    end
    chk(1'b0, "period timeout", n, 0);
  endtask

  // Called right after a rising edge; measures the high pulse length.
  task automatic pulse_len(input int ch, input bit do_wr, input logic [3:0] a,
                           input logic [15:0] d, output int n);
    n = 1;
    for (int k = 1; k < 500; k++) begin
      @(negedge clk);
      if (do_wr && k == 1) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
      if (k == 2) wr_en = 1'b0;
      if (pwm_o[ch]) n++;
      else begin wr_en = 1'b0; return; end
    end
  endtask

  task automatic t_reset;
    do_reset();
    chk(pwm_o == 4'h0, "R7 reset main level", int'(pwm_o), 0);
    chk(pwmn_o == 4'h0, "R8 reset comp level", int'(pwmn_o), 0);
  endtask

  task automatic t_basic;
    int k, n;
    do_reset();
    wr(4'd2, 16'd3);
    wr(4'd3, 16'd7);
    wr(4'd6, 16'h0011);
    start(16'd0, 16'd9, 16'h0005);
    count_high(0, 1'b0, 20, k);
    chk(k == 6, "R2 ch0 high cycles", k, 6);
    count_high(1, 1'b0, 20, k);
    chk(k == 14, "R2 ch1 high cycles", k, 14);
    wait_rise(0);
    next_rise(0, 1'b0, 4'd0, 16'd0, n);
    chk(n == 10, "R1 period", n, 10);
    wait_rise(1);
    next_rise(1, 1'b0, 4'd0, 16'd0, n);
    chk(n == 10, "R1 shared period ch1", n, 10);
  endtask

  task automatic t_psc;
    int k, n;
    do_reset();
    wr(4'd2, 16'd2);
    wr(4'd6, 16'h0001);
    start(16'd1, 16'd4, 16'h0005);
    wait_rise(0);
    next_rise(0, 1'b0, 4'd0, 16'd0, n);
    chk(n == 10, "R1 prescaled period", n, 10);
    count_high(0, 1'b0, 20, k);
    chk(k == 8, "R2 prescaled high cycles", k, 8);
    wr(4'd0, 16'd0);
    repeat (25) @(negedge clk);
    wait_rise(0);
    next_rise(0, 1'b0, 4'd0, 16'd0, n);
    chk(n == 5, "R6 prescaler loaded at wrap", n, 5);
  endtask

  task automatic t_edges;
    int k;
    do_reset();
    wr(4'd2, 16'd0);
    wr(4'd3, 16'd10);
    wr(4'd4, 16'd11);
    wr(4'd6, 16'h0111);
    start(16'd0, 16'd9, 16'h0005);
    count_high(0, 1'b0, 20, k);
    chk(k == 0, "R3 compare zero", k, 0);
    count_high(1, 1'b0, 20, k);
    chk(k == 20, "R3 compare reload+1", k, 20);
    count_high(2, 1'b0, 20, k);
    chk(k == 20, "R3 compare above reload", k, 20);
  endtask

  task automatic t_pol;
    int k;
    do_reset();
    wr(4'd2, 16'd3);
    wr(4'd6, 16'h0023);
    start(16'd0, 16'd9, 16'h0005);
    count_high(0, 1'b0, 20, k);
    chk(k == 14, "R7 inverted main", k, 14);
    count_high(1, 1'b0, 20, k);
    chk(k == 20, "R7 disabled holds polarity", k, 20);
  endtask

  task automatic t_comp;
    int m0, m1, k;
    do_reset();
    wr(4'd2, 16'd3);
    wr(4'd3, 16'd3);
    wr(4'd6, 16'h08D5);
    start(16'd0, 16'd9, 16'h0005);
    m0 = 0; m1 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwmn_o[0] != !pwm_o[0]) m0++;
      if (pwmn_o[1] != pwm_o[1]) m1++;
    end
    chk(m0 == 0, "R8 comp inverse", m0, 0);
    chk(m1 == 0, "R8 comp with polarity", m1, 0);
    count_high(2, 1'b1, 20, k);
    chk(k == 20, "R8 comp disabled level", k, 20);
  endtask

  task automatic t_moe;
    int k, bad;
    do_reset();
    wr(4'd2, 16'd3);
    wr(4'd6, 16'h000F);
    start(16'd0, 16'd9, 16'h0001);
    count_high(0, 1'b0, 20, k);
    chk(k == 20, "R9 idle main", k, 20);
    count_high(0, 1'b1, 20, k);
    chk(k == 20, "R9 idle comp", k, 20);
    wr(4'd7, 16'h0005);
    repeat (3) @(negedge clk);
    count_high(0, 1'b0, 20, k);
    chk(k == 14, "R9 main after enable", k, 14);
    count_high(0, 1'b1, 20, k);
    chk(k == 6, "R9 comp after enable", k, 6);
    kill_i = 1'b1;
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!(pwm_o[0] && pwmn_o[0])) bad++;
    end
    chk(bad == 0, "R9 kill forces idle", bad, 0);
    kill_i = 1'b0;
    count_high(0, 1'b0, 20, k);
    chk(k == 20, "R9 idle after kill main", k, 20);
    count_high(0, 1'b1, 20, k);
    chk(k == 20, "R9 idle after kill comp", k, 20);
    wr(4'd7, 16'h0005);
    repeat (3) @(negedge clk);
    count_high(0, 1'b0, 20, k);
    chk(k == 14, "R9 rearmed", k, 14);
  endtask

  task automatic t_arr;
    int n;
    do_reset();
    wr(4'd2, 16'd3);
    wr(4'd6, 16'h0001);
    start(16'd0, 16'd9, 16'h0007);
    wait_rise(0);
    next_rise(0, 1'b1, 4'd1, 16'd14, n);
    chk(n == 10, "R4 buffered reload waits", n, 10);
    next_rise(0, 1'b0, 4'd0, 16'd0, n);
    chk(n == 15, "R4 buffered reload applied", n, 15);
    wr(4'd7, 16'h0005);
    wait_rise(0);
    next_rise(0, 1'b1, 4'd1, 16'd19, n);
    chk(n == 20, "R4 direct reload", n, 20);
  endtask

  task automatic t_cmp;
    int n;
    do_reset();
    wr(4'd2, 16'd3);
    wr(4'd6, 16'h0001);
    start(16'd0, 16'd9, 16'h000D);
    wait_rise(0);
    pulse_len(0, 1'b1, 4'd2, 16'd6, n);
    chk(n == 3, "R5 buffered compare waits", n, 3);
    wait_rise(0);
    pulse_len(0, 1'b0, 4'd0, 16'd0, n);
    chk(n == 6, "R5 buffered compare applied", n, 6);
    wr(4'd7, 16'h0005);
    wait_rise(0);
    pulse_len(0, 1'b1, 4'd2, 16'd8, n);
    chk(n == 8, "R5 direct compare", n, 8);
  endtask

  task automatic t_ug;
    int n;
    do_reset();
    wr(4'd2, 16'd3);
    wr(4'd6, 16'h0001);
    start(16'd0, 16'd9, 16'h0007);
    wr(4'd1, 16'd19);
    wr(4'd8, 16'd0);
    wait_rise(0);
    next_rise(0, 1'b0, 4'd0, 16'd0, n);
    chk(n == 20, "R6 strobe loads reload", n, 20);
    wr(4'd0, 16'd1);
    wr(4'd8, 16'd0);
    wait_rise(0);
    next_rise(0, 1'b0, 4'd0, 16'd0, n);
    chk(n == 40, "R6 strobe loads prescaler", n, 40);
  endtask

  task automatic t_stop;
    int k, chg;
    logic v;
    do_reset();
    wr(4'd2, 16'd3);
    wr(4'd6, 16'h0001);
    start(16'd0, 16'd9, 16'h0005);
    wr(4'd7, 16'h0004);
    repeat (3) @(negedge clk);
    v = pwm_o[0];
    chg = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm_o[0] != v) chg++;
    end
    chk(chg == 0, "R10 frozen output", chg, 0);
    wr(4'd7, 16'h0005);
    repeat (3) @(negedge clk);
    count_high(0, 1'b0, 20, k);
    chk(k == 6, "R10 resumes", k, 6);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_psc();
    t_edges();
    t_pol();
    t_comp();
    t_moe();
    t_arr();
    t_cmp();
    t_ug();
    t_stop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule